// File: doc/BRIEF.md
# Arithmetic Right Shift Unit with Carry Flag

This block is the signed right-shift unit of a processor integer pipeline. It takes a 32-bit operand and a shift amount read from a register. It returns the shifted result together with a carry flag for the status register, and both appear one clock after the input strobe.

The carry flag answers one question: did a negative operand lose any one-bits off its low end? A positive operand never sets it. Shift amounts from 32 to 63 saturate, so the result becomes 32 copies of the sign bit and the carry equals that sign bit. The shift-amount port is wider than six bits, and its upper bits are ignored.

The operand is shifted through a logarithmic ladder of stages. Each stage also records whether it dropped a one-bit. A single output register stage holds the result, the carry and the valid flag.

Top module: `sra_carry_unit`

## Requirements
- R1: While reset is asserted, and at the first clock after reset, res_o, carry_o and out_valid_o are all 0.
- R2: out_valid_o equals in_valid_i of the previous clock edge.
- R3: When bit 5 of amt_i is 0, res_o is op_i shifted right arithmetically by amt_i[4:0], with the sign bit filling from the left.
- R4: When bit 5 of amt_i is 0, carry_o is 1 exactly when op_i[31] is 1 and at least one of the amt_i[4:0] lowest bits of op_i is 1. Otherwise carry_o is 0.
- R5: When bit 5 of amt_i is 1, res_o is 32 copies of op_i[31] and carry_o equals op_i[31].
- R6: When amt_i[5:0] is 0, res_o equals op_i and carry_o is 0.
- R7: Bits amt_i[7:6] have no effect on res_o or carry_o.
- R8: In a cycle where in_valid_i is 0, res_o and carry_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand and amount are valid |
| op_i | input | 32 | Signed operand |
| amt_i | input | 8 | Shift amount; only bits 5:0 are used |
| out_valid_o | output | 1 | Registered valid |
| res_o | output | 32 | Registered shifted result |
| carry_o | output | 1 | Registered carry flag |

## Verification
Positive operands are shifted with ones in their low bits, and the carry must stay 0. This separates a carry taken from the lost bits alone from one gated by the sign. Negative operands are shifted twice: once with ones in the discarded field, and once with only zeros there. That pair separates the lost-bit detection from a carry that simply copies the sign. Amounts of 31, 32 and 63 probe the saturation edge, and amounts of zero test the pass-through case. Amounts with bits 7:6 set, streams of back-to-back operands and idle gaps show that the unused amount bits are ignored, that outputs do not leak from one operand to the next, and that the outputs hold their values.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_AMT_W  = 8;
endpackage

// File: rtl/sra_stage.sv
module sra_stage #(
  parameter int unsigned W    = 32,
  parameter int unsigned DIST = 1
) (
  input  logic [W-1:0] d_i,
  input  logic         en_i,
  input  logic         lost_i,
  output logic [W-1:0] q_o,
  output logic         lost_o
);
  logic [W-1:0] shifted;
  assign shifted = {{DIST{d_i[W-1]}}, d_i[W-1:DIST]};
  assign q_o     = en_i ? shifted : d_i;
  // accumulate whether any one-bit fell off the low end
  assign lost_o  = lost_i | (en_i & (|d_i[DIST-1:0]));
endmodule

// File: rtl/sra_barrel.sv
module sra_barrel #(
  parameter int unsigned W = 32,
  localparam int unsigned LOG = $clog2(W)
) (
  input  logic [W-1:0]   d_i,
  input  logic [LOG-1:0] amt_i,
  output logic [W-1:0]   q_o,
  output logic           lost_o
);
  logic [W-1:0] lvl  [0:LOG];
  logic         lost [0:LOG];

  assign lvl[0]  = d_i;
  assign lost[0] = 1'b0;

  for (genvar k = 0; k < LOG; k++) begin : g_stage
    sra_stage #(.W(W), .DIST(1 << k)) u_stage (
      .d_i   (lvl[k]),
      .en_i  (amt_i[k]),
      .lost_i(lost[k]),
      .q_o   (lvl[k+1]),
      .lost_o(lost[k+1])
    );
  end

  assign q_o    = lvl[LOG];
  assign lost_o = lost[LOG];
endmodule

// File: rtl/sra_out_reg.sv
module sra_out_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] res_i,
  input  logic         carry_i,
  output logic         vld_o,
  output logic [W-1:0] res_o,
  output logic         carry_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      res_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        res_o   <= res_i;
        carry_o <= carry_i;
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  a_r2_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(res_o) && $stable(carry_o)));
endmodule

// File: rtl/sra_carry_unit.sv
module sra_carry_unit
  import sra_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned AMT_W  = DEF_AMT_W,
  localparam int unsigned LOG   = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] op_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  logic              sign;
  logic              sat;
  logic [DATA_W-1:0] shifted;
  logic              lost;
  logic [DATA_W-1:0] res_d;
  logic              carry_d;

  assign sign = op_i[DATA_W-1];
  assign sat  = amt_i[LOG];

  if (AMT_W > LOG + 1) begin : g_unused_amt
    logic unused_amt_hi;
    assign unused_amt_hi = ^amt_i[AMT_W-1:LOG+1];
  end

  sra_barrel #(.W(DATA_W)) u_barrel (
    .d_i   (op_i),
    .amt_i (amt_i[LOG-1:0]),
    .q_o   (shifted),
    .lost_o(lost)
  );

  always_comb begin
    if (sat) begin
      res_d   = {DATA_W{sign}};
      carry_d = sign;
    end else begin
      res_d   = shifted;
      carry_d = sign & lost;
    end
  end

  sra_out_reg #(.W(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (in_valid_i),
    .res_i  (res_d),
    .carry_i(carry_d),
    .vld_o  (out_valid_o),
    .res_o  (res_o),
    .carry_o(carry_o)
  );

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |=> (!out_valid_o && res_o == '0 && !carry_o));
  a_r5_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && amt_i[LOG]) |=>
      (res_o == {DATA_W{$past(op_i[DATA_W-1])}} && carry_o == $past(op_i[DATA_W-1])));
  a_r6_zero_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && amt_i[LOG:0] == '0) |=> (res_o == $past(op_i) && !carry_o));
  a_r4_positive_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !op_i[DATA_W-1]) |=> !carry_o);
  a_r3_sign_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (res_o[DATA_W-1] == $past(op_i[DATA_W-1])));
endmodule

// File: tb/sra_carry_unit_test.sv
`timescale 1ns/1ps
module sra_carry_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op = '0;
  logic [7:0]  amt = '0;
  logic        out_valid;
  logic [31:0] res;
  logic        carry;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] last_res;
  logic        last_carry;

  always #2.5 clk = ~clk;

  sra_carry_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid),
    .op_i(op), .amt_i(amt),
    .out_valid_o(out_valid), .res_o(res), .carry_o(carry)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_res(input logic [31:0] a, input logic [7:0] s);
    if (s[5]) return {32{a[31]}};
    return 32'($signed(a) >>> s[4:0]);
  endfunction

  function automatic logic exp_carry(input logic [31:0] a, input logic [7:0] s);
    logic [63:0] mask;
    if (s[5]) return a[31];
    mask = (64'd1 << s[4:0]) - 64'd1;
    return a[31] && ((64'(a) & mask) != 64'd0);
  endfunction

  // drive at negedge, result visible after next posedge, sampled at next negedge
  task automatic apply(input string req, input logic [31:0] a, input logic [7:0] s);
    in_valid = 1'b1; op = a; amt = s;
    @(negedge clk);
    chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({req, " res"}, res, exp_res(a, s));
    chk({req, " carry"}, {31'd0, carry}, {31'd0, exp_carry(a, s)});
    last_res = exp_res(a, s);
    last_carry = exp_carry(a, s);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0; op = 32'hA5A5_5A5A; amt = 8'h03;
      @(negedge clk);
      chk("R2 valid low", {31'd0, out_valid}, 32'd0);
      chk("R8 res held", res, last_res);
      chk("R8 carry held", {31'd0, carry}, {31'd0, last_carry});
    end
  endtask

  task automatic t_reset();
    chk("R1 valid reset", {31'd0, out_valid}, 32'd0);
    chk("R1 res reset", res, 32'd0);
    chk("R1 carry reset", {31'd0, carry}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid after", {31'd0, out_valid}, 32'd0);
    chk("R1 res after", res, 32'd0);
    last_res = '0; last_carry = 1'b0;
  endtask

  task automatic t_zero();
    apply("R6 zero neg", 32'h8000_0001, 8'h00);
    chk("R6 pass", res, 32'h8000_0001);
    chk("R6 carry0", {31'd0, carry}, 32'd0);
    apply("R6 zero pos", 32'h1234_5678, 8'h00);
  endtask

  task automatic t_positive();
    apply("R3 pos", 32'h7FFF_FFFF, 8'd4);
    apply("R4 pos ones lost", 32'h0000_00FF, 8'd8);
    chk("R4 pos carry0", {31'd0, carry}, 32'd0);
    apply("R3 pos 31", 32'h4000_0000, 8'd31);
  endtask

  task automatic t_negative();
    apply("R4 neg lost", 32'hFFFF_FF01, 8'd1);
    chk("R4 carry1", {31'd0, carry}, 32'd1);
    apply("R4 neg exact", 32'hFFFF_FF00, 8'd8);
    chk("R4 carry0", {31'd0, carry}, 32'd0);
    apply("R4 neg edge", 32'hFFFF_FF00, 8'd9);
    chk("R4 carry edge", {31'd0, carry}, 32'd1);
    apply("R3 neg 31", 32'h8000_0000, 8'd31);
    chk("R3 all ones", res, 32'hFFFF_FFFF);
  endtask

  task automatic t_saturate();
    apply("R5 neg 32", 32'h8000_0000, 8'd32);
    chk("R5 carry sign", {31'd0, carry}, 32'd1);
    apply("R5 pos 63", 32'h7FFF_FFFF, 8'd63);
    chk("R5 zero", res, 32'd0);
    apply("R5 neg 40", 32'hC000_0003, 8'd40);
  endtask

  task automatic t_upper();
    apply("R7 hi bits 0xC4", 32'hF000_000F, 8'hC4);
    chk("R7 res", res, 32'hFF00_0000);
    chk("R7 carry", {31'd0, carry}, 32'd1);
    apply("R7 hi bits 0x40", 32'h0000_0010, 8'h40);
    chk("R7 zero amt", res, 32'h0000_0010);
    apply("R7 hi sat", 32'h8000_0000, 8'hA0);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 64; i++)
      apply("R3 stream", 32'h9E37_79B9 * (i + 1), 8'(i * 7));
    idle(2);
  endtask

  initial begin
    #20000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_zero();
    idle(2);
    t_positive();
    t_negative();
    idle(1);
    t_saturate();
    t_upper();
    idle(3);
    t_stream();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule